// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This unit holds two independent 48-bit event counters that a processor core drives and that software programs over a simple memory-mapped register bus. Each channel has a 16-bit control word. The control word selects one of 64 event inputs with a 6-bit code, chooses whether that input is counted per rising strobe or per cycle it stays high, gates counting with two separate run bits, and clears the count with a write-one command. The unit raises no interrupt. A count saturates at all-ones and never wraps.

The bus has two regions, chosen by a region select input. Region 0 holds the two control words. Region 1 holds the counts, each read as a high word and a low word. Reading a low word latches the upper 16 count bits of that channel into a shadow register. A following read of the high word then gives a 48-bit value that matches the low word. Event inputs are one-cycle strobes or level conditions from the core. An internal two-flop synchronizer releases the active-low reset.

Top module: `evctr_dual_top`

## Requirements
- R1: After reset, both control words read 0x0000, and all four count words read 0.
- R2: Each control word holds these fields: event code in bits [5:0], per-cycle (level) mode in bit 8, clear command in bit 13, start in bit 14 and enable in bit 15. Every other bit, including the clear bit, reads as 0. Channel 1 control is at region 0 offset 0x0 and channel 2 at offset 0x4. Accesses whose address bits [1:0] are not zero are ignored.
- R3: A channel counts only while its start bit and its enable bit are both 1.
- R4: With bit 8 at 0, the count rises by one for each 0-to-1 transition of the selected event input. An input held high for several cycles counts once.
- R5: With bit 8 at 1, the count rises by one for every cycle that the selected event input is high.
- R6: The supported codes are 0x01, 0x02, 0x04 to 0x0B, 0x0D to 0x10, 0x13 to 0x15, 0x18, 0x21, 0x22, 0x24, 0x25 and 0x27 to 0x29. These include 0x04, 0x07, 0x08, 0x10, 0x13, 0x21 and 0x24. Any other code, such as 0x00, 0x03 or 0x3F, counts nothing. Both channels accept the same set.
- R7: A control write with bit 13 set zeroes that channel's count at the same clock edge. The clear takes priority over an increment in that cycle, and the other fields of the same write take effect.
- R8: Writes to the count region have no effect, so software cannot load a count value.
- R9: Region 1 offsets: 0x0 is channel 1 high, 0x4 is channel 1 low, 0x8 is channel 2 high and 0xC is channel 2 low. A low word returns count[31:0]. A high word returns the shadowed count[47:32] in bits [15:0], with bits [31:16] at zero.
- R10: A read of a channel's low word copies that channel's count[47:32] into its shadow, which later high-word reads return.
- R11: The two channels count independently, each from its own selected input.
- R12: Between clears, a count changes only by +1 per cycle, and it holds at all-ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rgn | input | 1 | Region select: 0 for control words, 1 for counts |
| bus_addr | input | 4 | Byte offset within the region |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd, zero when no read |
| evt_in | input | 64 | Event inputs from the core, indexed by event code |

## Verification
The assertions check on every cycle the following rules:
- A count moves only by one step or to zero.
- A clear always leaves zero.
- A channel that is not running, or that has an unsupported code, holds its count.
- At most one control word is written per access.
- A low-word read loads the shadow.

Only the bench scenarios can show the following:
- The field layout and the address map.
- The difference between per-strobe and per-cycle counting.
- Which codes are supported.
- That a clear wins over a strobe in the same cycle.
- That writes to the count region are ignored.
- That the two channels do not interfere.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
  localparam int CTL_W        = 16;
  localparam int EVSEL_W      = 6;
  localparam int BIT_LEVEL    = 8;
  localparam int BIT_CLR      = 13;
  localparam int BIT_START    = 14;
  localparam int BIT_EN       = 15;
  localparam logic [CTL_W-1:0] CTL_KEEP_MASK = 16'hC13F;
  localparam int EVT_N        = 1 << EVSEL_W;
  localparam logic [EVT_N-1:0] DEF_SUP_MASK = 64'h0000_03B6_0139_EFF6;

  typedef enum logic {
    RGN_CTL = 1'b0,
    RGN_CNT = 1'b1
  } rgn_e;
endpackage

// File: rtl/evctr_evt_front.sv
module evctr_evt_front #(
  parameter int EVT_N = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt_in,
  output logic [EVT_N-1:0] evt_rise,
  output logic [EVT_N-1:0] evt_level
);
  logic [EVT_N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= evt_in;
  end

  always_comb begin
    evt_rise  = evt_in & ~prev_q;
    evt_level = evt_in;
  end

  // R4: a rising strobe cannot be reported two cycles running
  assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rise != '0) |=> ((evt_rise & $past(evt_rise)) == '0));
endmodule

// File: rtl/evctr_channel.sv
module evctr_channel
  import evctr_pkg::*;
#(
  parameter int               CNT_W    = 48,
  parameter int               NEVT     = 64,
  parameter logic [NEVT-1:0]  SUP_MASK = DEF_SUP_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic [NEVT-1:0]  evt_rise,
  input  logic [NEVT-1:0]  evt_level,
  output logic [CTL_W-1:0] ctl_rd,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CTL_W-1:0]   ctl_q, ctl_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [EVSEL_W-1:0] sel;
  logic               hit, run, clr, at_max, cnt_en, supported;

  always_comb begin
    sel       = ctl_q[EVSEL_W-1:0];
    supported = SUP_MASK[sel];
    hit       = supported & (ctl_q[BIT_LEVEL] ? evt_level[sel] : evt_rise[sel]);
    run       = ctl_q[BIT_START] & ctl_q[BIT_EN];
    clr       = ctl_we & ctl_wdata[BIT_CLR];
    at_max    = &cnt_q;
  end

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) ctl_d = ctl_wdata & CTL_KEEP_MASK;
  end

  always_comb begin
    cnt_en = clr | (run & hit & ~at_max);
    cnt_d  = cnt_q;
    if (clr)                       cnt_d = '0;
    else if (run & hit & ~at_max)  cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ctl_rd = ctl_q;
  assign count  = cnt_q;

  // R12: a count only steps by one or returns to zero
  assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == '0)));

  // R7: a clear always leaves zero, whatever the event inputs do
  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R3: a channel that is not running holds its count
  assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));

  // R6: an unsupported code holds the count
  assert_unsup_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!supported && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/evctr_bus.sv
module evctr_bus
  import evctr_pkg::*;
#(
  parameter int CH_N   = 2,
  parameter int CNT_W  = 48,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rgn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr,
  input  logic                        rd,
  input  logic [CH_N-1:0][CTL_W-1:0]  ctl_rd_all,
  input  logic [CH_N-1:0][CNT_W-1:0]  cnt_all,
  output logic [CH_N-1:0]             ctl_we,
  output logic [31:0]                 rdata
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int HI_W   = CNT_W - 32;

  logic [WORD_W-1:0]          word;
  logic                       aligned;
  logic [CH_N-1:0]            sh_cap;
  logic [CH_N-1:0][HI_W-1:0]  shadow_q, shadow_d;

  always_comb begin
    word    = addr[ADDR_W-1:2];
    aligned = (addr[1:0] == 2'b00);
    ctl_we  = '0;
    sh_cap  = '0;
    rdata   = '0;
    for (int c = 0; c < CH_N; c++) begin
      if (aligned && (rgn == RGN_CTL) && (word == WORD_W'(c))) begin
        ctl_we[c] = wr;
        if (rd) rdata = {{(32-CTL_W){1'b0}}, ctl_rd_all[c]};
      end
      if (aligned && (rgn == RGN_CNT) && (word == WORD_W'(2*c))) begin
        if (rd) rdata = {{(32-HI_W){1'b0}}, shadow_q[c]};
      end
      if (aligned && (rgn == RGN_CNT) && (word == WORD_W'(2*c+1))) begin
        sh_cap[c] = rd;
        if (rd) rdata = cnt_all[c][31:0];
      end
    end
  end

  always_comb begin
    shadow_d = shadow_q;
    for (int c = 0; c < CH_N; c++)
      if (sh_cap[c]) shadow_d[c] = cnt_all[c][CNT_W-1:32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= '0;
    else if (|sh_cap)   shadow_q <= shadow_d;
  end

  // R2: one bus access writes at most one control word
  assert_one_ctl_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_we));

  for (genvar g = 0; g < CH_N; g++) begin : g_shadow_chk
    // R10: a low-word read leaves the high part in the shadow
    assert_shadow_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sh_cap[g] |=> (shadow_q[g] == $past(cnt_all[g][CNT_W-1:32])));
  end
endmodule

// File: rtl/evctr_dual_top.sv
module evctr_dual_top
  import evctr_pkg::*;
#(
  parameter int                CH_N     = 2,
  parameter int                CNT_W    = 48,
  parameter int                ADDR_W   = 4,
  parameter logic [EVT_N-1:0]  SUP_MASK = DEF_SUP_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rgn,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CTL_W-1:0]  bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [EVT_N-1:0]  evt_in
);
  logic                       rst_meta_q, rst_sync_n;
  logic [EVT_N-1:0]           evt_rise, evt_level;
  logic [CH_N-1:0]            ctl_we;
  logic [CH_N-1:0][CTL_W-1:0] ctl_rd_all;
  logic [CH_N-1:0][CNT_W-1:0] cnt_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  evctr_evt_front #(.EVT_N(EVT_N)) front_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .evt_in    (evt_in),
    .evt_rise  (evt_rise),
    .evt_level (evt_level)
  );

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    evctr_channel #(
      .CNT_W    (CNT_W),
      .NEVT     (EVT_N),
      .SUP_MASK (SUP_MASK)
    ) ch_i (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .ctl_we    (ctl_we[g]),
      .ctl_wdata (bus_wdata),
      .evt_rise  (evt_rise),
      .evt_level (evt_level),
      .ctl_rd    (ctl_rd_all[g]),
      .count     (cnt_all[g])
    );
  end

  evctr_bus #(
    .CH_N   (CH_N),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) bus_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rgn        (bus_rgn),
    .addr       (bus_addr),
    .wr         (bus_wr),
    .rd         (bus_rd),
    .ctl_rd_all (ctl_rd_all),
    .cnt_all    (cnt_all),
    .ctl_we     (ctl_we),
    .rdata      (bus_rdata)
  );
endmodule

// File: tb/evctr_dual_top_tb_top.sv
module evctr_dual_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rgn = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] evt_in = '0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  evctr_dual_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rgn   (bus_rgn),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_in    (evt_in)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic rgn, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_rgn = rgn; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic rgn, input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rgn = rgn; bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int code, input int cyc);
    @(negedge clk);
    evt_in[code] = 1'b1;
    repeat (cyc) @(negedge clk);
    evt_in[code] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_read(1'b0, 4'h0, v); check("R1 ctl1", v, 32'h0);
    do_read(1'b0, 4'h4, v); check("R1 ctl2", v, 32'h0);
    for (int a = 0; a < 16; a += 4) begin
      do_read(1'b1, 4'(a), v); check("R1 count word", v, 32'h0);
    end
  endtask

  task automatic t_ctl_layout();
    logic [31:0] v;
    do_write(1'b0, 4'h0, 16'hFFFF);
    do_read(1'b0, 4'h0, v); check("R2 fields readback", v, 32'h0000_C13F);
    do_write(1'b0, 4'h1, 16'h0013);
    do_read(1'b0, 4'h0, v); check("R2 misaligned write ignored", v, 32'h0000_C13F);
    do_write(1'b0, 4'h4, 16'h0113);
    do_read(1'b0, 4'h4, v); check("R2 ch2 at 0x4", v, 32'h0000_0113);
    do_read(1'b0, 4'h0, v); check("R2 ch1 untouched", v, 32'h0000_C13F);
    do_write(1'b0, 4'h0, 16'h0000);
    do_write(1'b0, 4'h4, 16'h0000);
    do_read(1'b0, 4'h0, v); check("R2 ch1 zeroed", v, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    do_write(1'b0, 4'h0, 16'hE013);
    for (int i = 1; i <= 3; i++) begin
      pulse(8'h13, 1);
      do_read(1'b1, 4'h4, v); check("R4 R12 strobe step", v, 32'(i));
    end
    pulse(8'h13, 5);
    do_read(1'b1, 4'h4, v); check("R4 held input counts once", v, 32'd4);
  endtask

  task automatic t_level();
    logic [31:0] v;
    do_write(1'b0, 4'h0, 16'hE113);
    do_read(1'b1, 4'h4, v); check("R7 clear on write", v, 32'd0);
    pulse(8'h13, 5);
    do_read(1'b1, 4'h4, v); check("R5 per-cycle count", v, 32'd5);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    do_write(1'b0, 4'h0, 16'hE013);
    do_write(1'b0, 4'h0, 16'h4013);
    pulse(8'h13, 1);
    do_read(1'b1, 4'h4, v); check("R3 start only", v, 32'd0);
    do_write(1'b0, 4'h0, 16'h8013);
    pulse(8'h13, 1);
    do_read(1'b1, 4'h4, v); check("R3 enable only", v, 32'd0);
    do_write(1'b0, 4'h0, 16'hC013);
    pulse(8'h13, 1);
    do_read(1'b1, 4'h4, v); check("R3 both set", v, 32'd1);
  endtask

  task automatic t_codes();
    logic [31:0] v;
    int sup[7] = '{8'h04, 8'h07, 8'h08, 8'h10, 8'h13, 8'h21, 8'h24};
    int uns[3] = '{8'h00, 8'h03, 8'h3F};
    foreach (sup[i]) begin
      do_write(1'b0, 4'h0, 16'hE000 | 16'(sup[i]));
      pulse(sup[i], 1);
      pulse(8'h02 == sup[i] ? 8'h01 : 8'h02, 1);
      do_read(1'b1, 4'h4, v); check("R6 supported code", v, 32'd1);
    end
    foreach (uns[i]) begin
      do_write(1'b0, 4'h0, 16'hE100 | 16'(uns[i]));
      pulse(uns[i], 3);
      do_read(1'b1, 4'h4, v); check("R6 unsupported code", v, 32'd0);
    end
  endtask

  task automatic t_clear_prio();
    logic [31:0] v;
    do_write(1'b0, 4'h0, 16'hE013);
    pulse(8'h13, 1);
    do_read(1'b1, 4'h4, v); check("R7 pre-count", v, 32'd1);
    @(negedge clk);
    bus_rgn = 1'b0; bus_addr = 4'h0; bus_wdata = 16'hE013; bus_wr = 1'b1;
    evt_in[8'h13] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; evt_in[8'h13] = 1'b0;
    do_read(1'b1, 4'h4, v); check("R7 clear beats strobe", v, 32'd0);
    do_read(1'b0, 4'h0, v); check("R2 R7 clear bit reads 0", v, 32'h0000_C013);
  endtask

  task automatic t_count_wr();
    logic [31:0] v;
    pulse(8'h13, 1);
    do_write(1'b1, 4'h4, 16'hFFFF);
    do_write(1'b1, 4'h0, 16'hFFFF);
    do_read(1'b1, 4'h4, v); check("R8 low unchanged", v, 32'd1);
    do_read(1'b1, 4'h0, v); check("R8 high unchanged", v, 32'd0);
  endtask

  task automatic t_indep();
    logic [31:0] v;
    do_write(1'b0, 4'h0, 16'hE104);
    do_write(1'b0, 4'h4, 16'hE021);
    @(negedge clk);
    evt_in[8'h04] = 1'b1; evt_in[8'h21] = 1'b1;
    @(negedge clk);
    evt_in[8'h21] = 1'b0;
    @(negedge clk);
    evt_in[8'h21] = 1'b1;
    @(negedge clk);
    evt_in[8'h21] = 1'b0;
    @(negedge clk);
    evt_in[8'h04] = 1'b0;
    @(negedge clk);
    do_read(1'b1, 4'h4, v); check("R11 ch1 level count", v, 32'd4);
    do_read(1'b1, 4'h0, v); check("R9 R10 ch1 high word", v, 32'd0);
    do_read(1'b1, 4'hC, v); check("R11 R9 ch2 low at 0xC", v, 32'd2);
    do_read(1'b1, 4'h8, v); check("R9 R10 ch2 high at 0x8", v, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctl_layout();
    t_edge();
    t_level();
    t_gate();
    t_codes();
    t_clear_prio();
    t_count_wr();
    t_indep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule